// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a set of external interrupt request lines and the processor-side delivery network. Each interrupt pin owns a 64-bit redirection entry. The entry says whether the pin is masked, whether it is edge- or level-triggered, and which vector, destination and delivery mode a request on that pin produces. The engine keeps a pending bit for each pin. It repeatedly selects the lowest-numbered pin that is eligible and turns it into a delivery message. That message is handed downstream over a valid/ready handshake.

Level-triggered pins use an acknowledge loop. Delivering such a pin sets its in-service flag (remote IRR). The pin then stays silent until an end-of-interrupt broadcast carrying the matching vector clears that flag. If the line is still asserted at that point, the pin is delivered again.

Edge-triggered pins latch a request only while unmasked. A rising edge seen while the pin is masked is lost.

A pin whose delivery mode selects the external-interrupt path does not use the vector in its entry. Instead, the engine asks a legacy controller for the vector over a small request/acknowledge port.

Software reaches the table through a word-wide read/write port. The port is addressed by pin index and half-word.

Top module: `irq_route_engine`

## Requirements
- R1: After reset, the low word of every entry reads 0x0001_0000 (only mask bit 16 set) and the high word reads 0. No message is valid, no external-vector request is raised, and no pending request survives.
- R2: Table port behaviour:
  - A write with `tbl_we` replaces the high word (bits 63:32) when `tbl_hi`=1 and the low word (bits 31:0) when `tbl_hi`=0.
  - `tbl_rdata` shows the addressed word one cycle after the address is presented.
  - A pin index at or above the pin count is never written and always reads 0.
- R3: Entry field positions:

  | Field | Bits |
  |---|---|
  | Vector | 7:0 |
  | Delivery mode | 10:8 |
  | Destination mode | 11 |
  | Polarity | 13 |
  | Remote IRR | 14 |
  | Trigger (1 = level, 0 = edge) | 15 |
  | Mask | 16 |
  | Destination | 63:56 |

  An unmasked level pin whose line is high is delivered as one message. That message carries these fields of its entry.
- R4: Delivering a level pin sets its remote IRR bit. While that bit is set, the pin is not delivered again, even though its line stays high.
- R5: An end-of-interrupt with vector V clears remote IRR on every entry whose bit 14 is set and whose vector equals V. If that pin is unmasked and its line is still high, it is delivered again. An end-of-interrupt with any other vector changes nothing.
- R6: An unmasked edge pin produces exactly one message per rising edge. A line that stays high does not repeat.
- R7: A rising edge on a masked edge pin is discarded. Unmasking the pin afterwards produces no message.
- R8: Level pins and table writes:
  - A masked level pin with a high line is delivered as soon as a table write unmasks it.
  - A level line that was lowered before the unmask leaves nothing pending.
- R9: When several pins are eligible at once, the lowest pin index is delivered first. The others follow in ascending order.
- R10: Delivery mode 7 (external interrupt):
  - The engine raises `ext_req`. It takes the message vector from `ext_vector` in the cycle `ext_ack` is high, not from the entry.
  - Modes 0 (fixed), 1 (lowest priority), 2, 4 (NMI), 5 (INIT) and 6 (startup) use entry bits 7:0 as the vector.
- R11: Input line 0 drives pin 2. Every other line n drives pin n. Lines at or beyond the pin count have no effect.
- R12: A message stays valid with unchanged fields until `msg_ready` is seen high. Only one message is outstanding at a time.
- R13: If a table write to a level pin's low word lands in the same cycle that the pin is selected for delivery, the write takes effect and remote IRR still ends up set. The message carries the entry as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_LINES | External interrupt request lines, active high |
| tbl_we | input | 1 | Table word write strobe |
| tbl_idx | input | IDX_W | Pin index for table access |
| tbl_hi | input | 1 | Selects high (1) or low (0) 32-bit word |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Registered table read data |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_dest | output | 8 | Destination field |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Interrupt vector |
| msg_polarity | output | 1 | Polarity field |
| msg_trigger | output | 1 | Trigger mode (1 = level) |
| ext_req | output | 1 | Request for a vector from the legacy controller |
| ext_ack | input | 1 | Legacy controller supplies the vector |
| ext_vector | input | 8 | Vector from the legacy controller |

## Verification
Two things can happen to the same level pin in one clock: the engine can select it for delivery, and a table write can rewrite its low word. The write may even clear bit 14 and change the vector. The bench raises the line in one cycle and places the write in the very next cycle, which is the cycle in which the engine commits that pin. It then judges three things. The outgoing message must still carry the old vector. A read-back must show the new vector with remote IRR set. An end-of-interrupt for the new vector must bring the pin back with the new vector.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ENT_W     = 64;
  localparam int VEC_W     = 8;
  localparam int B_DMODE   = 8;
  localparam int B_DSTMODE = 11;
  localparam int B_POL     = 13;
  localparam int B_RIRR    = 14;
  localparam int B_TRIG    = 15;
  localparam int B_MASK    = 16;
  localparam int B_DEST    = 56;
  localparam logic [2:0] DM_EXTERNAL = 3'd7;
  localparam logic [ENT_W-1:0] ENT_RESET = ENT_W'(1) << B_MASK;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXT,
    ST_SEND
  } eng_state_t;
endpackage

// File: rtl/irq_line_map.sv
// Steers request lines onto pins and detects rising edges per pin.
module irq_line_map #(
  parameter int NUM_LINES = 32,
  parameter int NUM_PINS  = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_PINS-1:0]  pin_lvl,
  output logic [NUM_PINS-1:0]  pin_rise
);
  logic [NUM_PINS-1:0] pin_q;

  always_comb begin
    pin_lvl = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      int tgt;
      tgt = (l == 0) ? 2 : l;
      if (tgt < NUM_PINS) pin_lvl[tgt] = pin_lvl[tgt] | line_in[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_lvl;
  end

  assign pin_rise = pin_lvl & ~pin_q;
endmodule

// File: rtl/irq_entry_table.sv
// Redirection entries, pending bits and the table read/write port.
module irq_entry_table
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    addr,
  input  logic                hi,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vec,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] pin_rise,
  input  logic                commit,
  input  logic [IDX_W-1:0]    commit_idx,
  output logic [ENT_W-1:0]    ent [NUM_PINS],
  output logic [NUM_PINS-1:0] irr
);
  logic [ENT_W-1:0]    ent_nx [NUM_PINS];
  logic [NUM_PINS-1:0] irr_nx;
  logic [31:0]         rd_word;
  logic                addr_ok;

  assign addr_ok = {1'b0, addr} < (IDX_W+1)'(NUM_PINS);

  // Order of updates: table write, then EOI clear, then commit set.
  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      logic [ENT_W-1:0] e;
      logic             hit;
      e   = ent[i];
      hit = commit && (commit_idx == IDX_W'(i));
      if (wr_en && addr == IDX_W'(i)) begin
        if (hi) e[63:32] = wdata;
        else    e[31:0]  = wdata;
      end
      if (eoi_valid && ent[i][B_RIRR] && ent[i][VEC_W-1:0] == eoi_vec)
        e[B_RIRR] = 1'b0;
      if (hit && ent[i][B_TRIG])
        e[B_RIRR] = 1'b1;
      ent_nx[i] = e;
      if (ent[i][B_TRIG])
        irr_nx[i] = pin_lvl[i];
      else
        irr_nx[i] = (irr[i] & ~hit) | (pin_rise[i] & ~ent[i][B_MASK]);
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr_ok) rd_word = hi ? ent[addr][63:32] : ent[addr][31:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) ent[i] <= ENT_RESET;
      irr   <= '0;
      rdata <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) ent[i] <= ent_nx[i];
      irr   <= irr_nx;
      rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irq_pick.sv
// Lowest-index-first selection among eligible pins.
module irq_pick #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic [NUM_PINS-1:0] eligible,
  output logic                any,
  output logic [IDX_W-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--)
      if (eligible[i]) idx = IDX_W'(i);
  end
  assign any = |eligible;
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = $clog2(NUM_PINS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 tbl_we,
  input  logic [IDX_W-1:0]     tbl_idx,
  input  logic                 tbl_hi,
  input  logic [31:0]          tbl_wdata,
  output logic [31:0]          tbl_rdata,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vector,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_dest,
  output logic                 msg_dest_mode,
  output logic [2:0]           msg_deliv_mode,
  output logic [7:0]           msg_vector,
  output logic                 msg_polarity,
  output logic                 msg_trigger,
  output logic                 ext_req,
  input  logic                 ext_ack,
  input  logic [7:0]           ext_vector
);
  logic [NUM_PINS-1:0] pin_lvl, pin_rise, irr, eligible;
  logic [ENT_W-1:0]    ent [NUM_PINS];
  logic                pick_any, commit;
  logic [IDX_W-1:0]    pick_idx;
  logic [ENT_W-1:0]    sel;
  eng_state_t          state;

  irq_line_map #(.NUM_LINES(NUM_LINES), .NUM_PINS(NUM_PINS)) u_map (
    .clk(clk), .rst(rst), .line_in(line_in),
    .pin_lvl(pin_lvl), .pin_rise(pin_rise)
  );

  irq_entry_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(tbl_we), .addr(tbl_idx), .hi(tbl_hi),
    .wdata(tbl_wdata), .rdata(tbl_rdata), .eoi_valid(eoi_valid),
    .eoi_vec(eoi_vector), .pin_lvl(pin_lvl), .pin_rise(pin_rise),
    .commit(commit), .commit_idx(pick_idx), .ent(ent), .irr(irr)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_elig
    assign eligible[p] = irr[p] & ~ent[p][B_MASK]
                       & ~(ent[p][B_TRIG] & ent[p][B_RIRR]);
  end

  irq_pick #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .eligible(eligible), .any(pick_any), .idx(pick_idx)
  );

  assign commit = (state == ST_IDLE) && pick_any;
  assign sel    = ent[pick_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      msg_valid      <= 1'b0;
      ext_req        <= 1'b0;
      msg_dest       <= '0;
      msg_dest_mode  <= 1'b0;
      msg_deliv_mode <= '0;
      msg_vector     <= '0;
      msg_polarity   <= 1'b0;
      msg_trigger    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (pick_any) begin
          msg_dest       <= sel[B_DEST +: 8];
          msg_dest_mode  <= sel[B_DSTMODE];
          msg_deliv_mode <= sel[B_DMODE +: 3];
          msg_vector     <= sel[VEC_W-1:0];
          msg_polarity   <= sel[B_POL];
          msg_trigger    <= sel[B_TRIG];
          if (sel[B_DMODE +: 3] == DM_EXTERNAL) begin
            ext_req <= 1'b1;
            state   <= ST_EXT;
          end else begin
            msg_valid <= 1'b1;
            state     <= ST_SEND;
          end
        end
        ST_EXT: if (ext_ack) begin
          msg_vector <= ext_vector;
          ext_req    <= 1'b0;
          msg_valid  <= 1'b1;
          state      <= ST_SEND;
        end
        ST_SEND: if (msg_ready) begin
          msg_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk (
  input logic       clk,
  input logic       rst,
  input logic       msg_valid,
  input logic       msg_ready,
  input logic [7:0] msg_dest,
  input logic [2:0] msg_deliv_mode,
  input logic [7:0] msg_vector,
  input logic       ext_req,
  input logic       ext_ack,
  input logic [7:0] ext_vector
);
  // R1: reset leaves the output side quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !msg_valid && !ext_req);

  // R12: a stalled message holds its fields
  p_hold_stable_r12: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)
      && $stable(msg_dest) && $stable(msg_deliv_mode));

  // R12: one message outstanding, accepted message drops valid
  p_single_out_r12: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready |=> !msg_valid);

  // R10: vector request and message never overlap
  p_ext_excl_r10: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> !msg_valid);

  // R10: acknowledged external vector becomes the message vector
  p_ext_vector_r10: assert property (@(posedge clk) disable iff (rst)
    ext_req && ext_ack |=> msg_valid && msg_vector == $past(ext_vector)
      && msg_deliv_mode == 3'd7);
endmodule

bind irq_route_engine irq_route_chk u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_dest(msg_dest), .msg_deliv_mode(msg_deliv_mode),
  .msg_vector(msg_vector), .ext_req(ext_req), .ext_ack(ext_ack),
  .ext_vector(ext_vector)
);

// File: tb/irq_route_engine_tb.sv
module irq_route_engine_tb;
  localparam int NP = 24;
  localparam int NL = 32;
  localparam int IW = 5;

  logic          clk = 0;
  logic          rst = 1;
  logic [NL-1:0] line_in = '0;
  logic          tbl_we = 0;
  logic [IW-1:0] tbl_idx = '0;
  logic          tbl_hi = 0;
  logic [31:0]   tbl_wdata = '0;
  logic [31:0]   tbl_rdata;
  logic          eoi_valid = 0;
  logic [7:0]    eoi_vector = '0;
  logic          msg_valid, msg_ready = 0;
  logic [7:0]    msg_dest, msg_vector;
  logic          msg_dest_mode, msg_polarity, msg_trigger;
  logic [2:0]    msg_deliv_mode;
  logic          ext_req, ext_ack = 0;
  logic [7:0]    ext_vector = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_route_engine #(.NUM_PINS(NP), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .line_in(line_in), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_hi(tbl_hi), .tbl_wdata(tbl_wdata),
    .tbl_rdata(tbl_rdata), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_deliv_mode(msg_deliv_mode),
    .msg_vector(msg_vector), .msg_polarity(msg_polarity),
    .msg_trigger(msg_trigger), .ext_req(ext_req), .ext_ack(ext_ack),
    .ext_vector(ext_vector)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm,
      input bit lvl, input bit msk, input logic [7:0] dst, input bit pol, input bit dsm);
    logic [63:0] e;
    e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = dsm; e[13] = pol;
    e[15] = lvl;  e[16] = msk;  e[63:56] = dst;
    return e;
  endfunction

  task automatic wr(input int idx, input bit hi, input logic [31:0] d);
    tbl_we = 1; tbl_idx = IW'(idx); tbl_hi = hi; tbl_wdata = d;
    tick();
    tbl_we = 0;
  endtask

  task automatic rd(input int idx, input bit hi, output logic [31:0] d);
    tbl_idx = IW'(idx); tbl_hi = hi;
    tick();
    d = tbl_rdata;
  endtask

  task automatic set_entry(input int idx, input logic [63:0] e);
    wr(idx, 1, e[63:32]);
    wr(idx, 0, e[31:0]);
  endtask

  task automatic wait_msg(input string req);
    int n = 0;
    while (!msg_valid && n < 30) begin tick(); n++; end
    check(msg_valid, req, {63'b0, msg_valid}, 64'd1);
  endtask

  task automatic accept();
    msg_ready = 1;
    tick();
    msg_ready = 0;
  endtask

  task automatic expect_msg(input string req, input logic [7:0] vec, input logic [2:0] dm);
    wait_msg(req);
    check(msg_vector == vec && msg_deliv_mode == dm, req,
          {53'b0, msg_deliv_mode, msg_vector}, {53'b0, dm, vec});
    accept();
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (msg_valid || ext_req) seen = 1;
    end
    check(!seen, req, {63'b0, seen}, 64'd0);
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1; eoi_vector = v;
    tick();
    eoi_valid = 0;
  endtask

  task automatic pulse(input int l);
    line_in[l] = 1;
    tick(); tick();
    line_in[l] = 0;
    tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(!msg_valid && !ext_req, "R1 outputs idle", {62'b0, msg_valid, ext_req}, 0);
    rd(0, 0, d);  check(d == 32'h0001_0000, "R1 entry0 low", d, 64'h10000);
    rd(23, 0, d); check(d == 32'h0001_0000, "R1 entry23 low", d, 64'h10000);
    rd(23, 1, d); check(d == 32'h0, "R1 entry23 high", d, 0);
  endtask

  task automatic t_table();
    logic [31:0] d;
    wr(7, 1, 32'hAB00_0000);
    wr(7, 0, 32'h0001_0033);
    rd(7, 1, d); check(d == 32'hAB00_0000, "R2 high word", d, 64'hAB000000);
    rd(7, 0, d); check(d == 32'h0001_0033, "R2 low word", d, 64'h10033);
    wr(28, 0, 32'h1234_5678);
    rd(28, 0, d); check(d == 32'h0, "R2 out of range reads 0", d, 0);
  endtask

  task automatic t_level();
    logic [63:0] e;
    logic [31:0] d;
    e = mk(8'h41, 3'd0, 1, 0, 8'h5A, 1, 1);
    set_entry(3, e);
    line_in[3] = 1;
    wait_msg("R3 level delivery");
    check({msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector, msg_polarity, msg_trigger}
          == {8'h5A, 1'b1, 3'd0, 8'h41, 1'b1, 1'b1}, "R3 message fields",
          {42'b0, msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector, msg_polarity, msg_trigger},
          {42'b0, 8'h5A, 1'b1, 3'd0, 8'h41, 1'b1, 1'b1});
    accept();
    expect_quiet(10, "R4 no redelivery while remote IRR set");
    rd(3, 0, d); check(d == (e[31:0] | 32'h4000), "R4 remote IRR bit14 set", d, e[31:0] | 32'h4000);
    eoi(8'h42);
    expect_quiet(8, "R5 non-matching EOI ignored");
    eoi(8'h41);
    expect_msg("R5 matching EOI re-delivers", 8'h41, 3'd0);
    line_in[3] = 0;
    tick();
    eoi(8'h41);
    expect_quiet(8, "R5 EOI with line low delivers nothing");
    rd(3, 0, d); check(d == e[31:0], "R5 remote IRR cleared", d, e[31:0]);
  endtask

  task automatic t_edge();
    set_entry(9, mk(8'h60, 3'd4, 0, 0, 8'h01, 0, 0));
    pulse(9);
    expect_msg("R6 edge delivers once", 8'h60, 3'd4);
    expect_quiet(6, "R6 no second message after one edge");
    line_in[9] = 1;
    expect_msg("R6 new edge delivers", 8'h60, 3'd4);
    expect_quiet(10, "R6 held line does not repeat");
    line_in[9] = 0;
    tick();
  endtask

  task automatic t_edge_masked();
    set_entry(10, mk(8'h61, 3'd0, 0, 1, 8'h02, 0, 0));
    pulse(10);
    wr(10, 0, mk(8'h61, 3'd0, 0, 0, 8'h02, 0, 0) >> 0);
    expect_quiet(8, "R7 masked edge discarded");
    pulse(10);
    expect_msg("R7 unmasked edge delivered", 8'h61, 3'd0);
  endtask

  task automatic t_level_masked();
    logic [63:0] m, u;
    m = mk(8'h63, 3'd1, 1, 1, 8'h03, 0, 0);
    u = mk(8'h63, 3'd1, 1, 0, 8'h03, 0, 0);
    set_entry(12, m);
    line_in[12] = 1; tick(); tick();
    line_in[12] = 0; tick();
    wr(12, 0, u[31:0]);
    expect_quiet(8, "R8 lowered level leaves nothing");
    m = mk(8'h62, 3'd0, 1, 1, 8'h03, 0, 0);
    u = mk(8'h62, 3'd0, 1, 0, 8'h03, 0, 0);
    set_entry(11, m);
    line_in[11] = 1;
    expect_quiet(6, "R8 masked level held off");
    wr(11, 0, u[31:0]);
    expect_msg("R8 unmask write delivers", 8'h62, 3'd0);
    line_in[11] = 0; tick();
    eoi(8'h62);
  endtask

  task automatic t_priority();
    set_entry(14, mk(8'h74, 3'd0, 0, 0, 8'h04, 0, 0));
    set_entry(6,  mk(8'h66, 3'd0, 0, 0, 8'h04, 0, 0));
    line_in[14] = 1; line_in[6] = 1;
    wait_msg("R9 first of two");
    check(msg_vector == 8'h66, "R9 lowest pin first", msg_vector, 64'h66);
    tick(); tick(); tick();
    check(msg_valid && msg_vector == 8'h66, "R12 held while not ready",
          {55'b0, msg_valid, msg_vector}, {55'b0, 1'b1, 8'h66});
    accept();
    expect_msg("R9 higher pin second", 8'h74, 3'd0);
    line_in[14] = 0; line_in[6] = 0;
    tick();
  endtask

  task automatic t_ext();
    int n = 0;
    set_entry(15, mk(8'h70, 3'd7, 0, 0, 8'h05, 0, 0));
    pulse(15);
    while (!ext_req && n < 20) begin tick(); n++; end
    check(ext_req && !msg_valid, "R10 external vector requested",
          {62'b0, ext_req, msg_valid}, 64'b10);
    tick();
    check(ext_req && !msg_valid, "R10 waits for ack", {62'b0, ext_req, msg_valid}, 64'b10);
    ext_ack = 1; ext_vector = 8'h99;
    tick();
    ext_ack = 0;
    expect_msg("R10 vector from legacy port", 8'h99, 3'd7);
  endtask

  task automatic t_steer();
    set_entry(2, mk(8'h22, 3'd0, 0, 0, 8'h06, 0, 0));
    set_entry(0, mk(8'h20, 3'd0, 0, 0, 8'h06, 0, 0));
    pulse(0);
    expect_msg("R11 line0 lands on pin2", 8'h22, 3'd0);
    expect_quiet(5, "R11 pin0 not driven by line0");
    pulse(30);
    expect_quiet(8, "R11 line beyond pin count ignored");
  endtask

  task automatic t_collide();
    logic [31:0] d;
    set_entry(5, mk(8'h55, 3'd0, 1, 0, 8'h07, 0, 0));
    line_in[5] = 1;
    tick();
    // pending bit set at the edge just passed; the next edge commits pin 5
    tbl_we = 1; tbl_idx = IW'(5); tbl_hi = 0; tbl_wdata = 32'h0000_8077;
    tick();
    tbl_we = 0;
    check(msg_valid && msg_vector == 8'h55, "R13 message carries old entry",
          {55'b0, msg_valid, msg_vector}, {55'b0, 1'b1, 8'h55});
    accept();
    rd(5, 0, d); check(d == 32'h0000_C077, "R13 write kept and remote IRR set", d, 64'hC077);
    eoi(8'h77);
    expect_msg("R13 new vector after EOI", 8'h77, 3'd0);
    line_in[5] = 0; tick();
    eoi(8'h77);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    tick();
    t_reset();
    t_table();
    t_level();
    t_edge();
    t_edge_masked();
    t_level_masked();
    t_priority();
    t_ext();
    t_steer();
    t_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule